// File: doc/BRIEF.md
# BERT Receive Pattern Synchronizer

This block is the receive half of a bit error rate tester. It takes one serial data bit per clock, qualified by a bit-enable strobe. It locks a local 32-bit pattern generator onto an incoming pseudo-random, QRSS or fixed repeating pattern. Lock is acquired in two steps. First, 32 received bits are copied straight into the generator. Then the following 32 bits must all agree with what the generator predicts.

Once locked, every enabled bit is compared with the prediction. Two saturating counters track the traffic: one counts the bits checked while in sync, and one counts the bits that disagreed. While locked, the block keeps a record of mismatches over a sliding window. If the errors in that window become too dense, it drops lock and goes back to acquisition, unless automatic resync has been switched off. Pattern selection, the polynomial taps and the two enables are static configuration inputs. A single-cycle clear pulse zeroes both counters.

Top module: `bert_rx_sync`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `in_sync` is 0 and both `bit_cnt` and `err_cnt` are 0.
- R2: Generator bit k is register position k-1, and each step shifts from bit 1 toward bit 32. `cfg_len_m1` holds n-1 and `cfg_tap_m1` holds y-1. With `cfg_repeat`=0 (pseudo-random) the predicted bit is bit n XOR bit y. With `cfg_repeat`=1 (repeating) it is bit n. Outside loading, the predicted bit is what shifts into bit 1, so a repeating pattern of any length from 1 to 32 locks and then checks with no errors.
- R3: `cfg_qrss`=1 overrides `cfg_repeat`. The feedback becomes bit 17 XOR bit 20, and the predicted bit is forced to 1 when bits 1 to 14 are all zero. In pseudo-random and QRSS modes the feedback is forced to 1 when bits 1 to 31 are all zero, so an all-zero input stream never locks.
- R4: After reset or loss of lock, 32 enabled bits are loaded and the next 32 enabled bits are checked. If all 32 match, `in_sync` goes high on the cycle after the 64th enabled bit and not earlier.
- R5: A mismatch during the checking phase restarts loading with the next enabled bit. Lock then takes a further 64 clean enabled bits.
- R6: A cycle with `rx_en` low changes no state, no counter and no output, whatever `rx_bit` carries.
- R7: While in sync with `cfg_auto_resync`=1, an enabled mismatching bit drops `in_sync` on the next cycle if that bit and the 63 in-sync bits before it hold 6 or more mismatches. Acquisition then restarts from that point.
- R8: With `cfg_auto_resync`=0, lock is never lost, however many mismatches arrive.
- R9: `bit_cnt` counts the enabled bits processed while in sync, and `err_cnt` counts the mismatches among them. Bits processed out of sync change neither counter.
- R10: Both counters stop at their all-ones value instead of wrapping.
- R11: A cycle with `cnt_clr` high leaves both counters at 0 on the next cycle, even if a counted bit arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Received serial data bit |
| rx_en | input | 1 | Bit-enable strobe; only qualified bits are processed |
| cfg_repeat | input | 1 | 0 = pseudo-random polynomial, 1 = repeating pattern |
| cfg_qrss | input | 1 | 1 = QRSS generator, overrides cfg_repeat |
| cfg_len_m1 | input | 5 | Pattern length or polynomial order n, minus one |
| cfg_tap_m1 | input | 5 | Second polynomial tap y, minus one |
| cfg_auto_resync | input | 1 | 1 = drop lock on dense errors |
| cnt_clr | input | 1 | Clear pulse for both counters |
| in_sync | output | 1 | Pattern lock indicator |
| bit_cnt | output | BIT_W | Saturating count of bits checked in sync |
| err_cnt | output | ERR_W | Saturating count of mismatched bits in sync |

## Verification
A generator register that is shifted wrongly or tapped at the wrong position shows at the ports as soon as lock is attempted. `in_sync` fails to rise exactly 64 enabled bits after acquisition starts, or `err_cnt` climbs on a clean stream within a pattern period. A window tally that is off by one moves the boundary between keeping and losing lock. The bench finds that boundary by sweeping the spacing between six errors: at a spacing of 12 bits or less lock must drop, and at 13 or more it must be held. A phase index that is one step off moves the rise of `in_sync` by one cycle, and the bench checks it both on the bit before and on the bit that should complete acquisition.

// File: rtl/bert_rx_pkg.sv
package bert_rx_pkg;

    localparam int GEN_W      = 32;
    localparam int QRSS_TAP_A = 17;
    localparam int QRSS_TAP_B = 20;
    localparam int QRSS_RUN   = 14;
    localparam int PHASE_W    = $clog2(2 * GEN_W);

    typedef enum logic [1:0] {
        ST_LOAD   = 2'd0,
        ST_VERIFY = 2'd1,
        ST_SYNC   = 2'd2
    } sync_state_e;

    typedef enum logic {
        PAT_PRBS   = 1'b0,
        PAT_REPEAT = 1'b1
    } pat_kind_e;

    typedef struct packed {
        pat_kind_e  kind;
        logic       qrss;
        logic [4:0] len_m1;
        logic [4:0] tap_m1;
    } pat_cfg_t;

    typedef struct packed {
        sync_state_e        state;
        logic [PHASE_W-1:0] idx;
    } sync_ctx_t;

    // Predicted next bit of the local generator for the given register contents.
    function automatic logic gen_predict(input logic [GEN_W-1:0] g, input pat_cfg_t c);
        logic fb;
        if (c.qrss)
            fb = g[QRSS_TAP_A-1] ^ g[QRSS_TAP_B-1];
        else if (c.kind == PAT_REPEAT)
            fb = g[c.len_m1];
        else
            fb = g[c.len_m1] ^ g[c.tap_m1];
        if ((c.qrss || c.kind == PAT_PRBS) && (g[GEN_W-2:0] == '0))
            fb = 1'b1;
        if (c.qrss && (g[QRSS_RUN-1:0] == '0))
            fb = 1'b1;
        return fb;
    endfunction

endpackage

// File: rtl/bert_rx_patgen.sv
module bert_rx_patgen
    import bert_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pat_cfg_t cfg,
    input  logic     shift_en,
    input  logic     load_sel,
    input  logic     rx_bit,
    output logic     pred
);

    logic [GEN_W-1:0] gen_q;
    logic             shift_in;

    always_comb begin
        pred     = gen_predict(gen_q, cfg);
        shift_in = load_sel ? rx_bit : pred;
    end

    always_ff @(posedge clk) begin
        if (rst)
            gen_q <= '0;
        else if (shift_en)
            gen_q <= {gen_q[GEN_W-2:0], shift_in};
    end

    AST_NO_ZERO_LOCKUP: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !load_sel && (cfg.qrss || cfg.kind == PAT_PRBS))
        |=> (gen_q[GEN_W-2:0] != '0)) else $error("zero lockup");  // R3

endmodule

// File: rtl/bert_rx_errwin.sv
module bert_rx_errwin #(
    parameter int WIN    = 64,
    parameter int THRESH = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic upd,
    input  logic mis,
    output logic trip
);

    localparam int CW = $clog2(WIN + 1);

    logic [WIN-1:0] hist_q;
    logic [CW-1:0]  tally_q;
    logic [CW-1:0]  tally_nx;

    always_comb begin
        tally_nx = tally_q + CW'(mis) - CW'(hist_q[WIN-1]);
        trip     = upd && (tally_nx >= CW'(THRESH));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hist_q  <= '0;
            tally_q <= '0;
        end else if (upd) begin
            hist_q  <= {hist_q[WIN-2:0], mis};
            tally_q <= tally_nx;
        end
    end

    AST_WIN_TALLY: assert property (@(posedge clk) disable iff (rst)
        tally_q == CW'($countones(hist_q))) else $error("window tally");  // R7

    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (rst)
        tally_q <= CW'(WIN)) else $error("window bound");  // R7

endmodule

// File: rtl/bert_rx_satcnt.sv
module bert_rx_satcnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clr)
            q <= '0;
        else if (inc && (q != TOP))
            q <= q + W'(1);
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (q == TOP && !clr) |=> (q == TOP)) else $error("counter wrapped");  // R10

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!inc && !clr) |=> $stable(q)) else $error("counter moved");  // R9

endmodule

// File: rtl/bert_rx_sync.sv
module bert_rx_sync
    import bert_rx_pkg::*;
#(
    parameter int BIT_W  = 32,
    parameter int ERR_W  = 24,
    parameter int WIN    = 64,
    parameter int THRESH = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_bit,
    input  logic             rx_en,
    input  logic             cfg_repeat,
    input  logic             cfg_qrss,
    input  logic [4:0]       cfg_len_m1,
    input  logic [4:0]       cfg_tap_m1,
    input  logic             cfg_auto_resync,
    input  logic             cnt_clr,
    output logic             in_sync,
    output logic [BIT_W-1:0] bit_cnt,
    output logic [ERR_W-1:0] err_cnt
);

    localparam logic [PHASE_W-1:0] LAST = PHASE_W'(GEN_W - 1);

    pat_cfg_t  cfg;
    sync_ctx_t ctx_q, ctx_nx;
    logic      pred, mis, trip, chk_upd;

    always_comb begin
        cfg.kind   = cfg_repeat ? PAT_REPEAT : PAT_PRBS;
        cfg.qrss   = cfg_qrss;
        cfg.len_m1 = cfg_len_m1;
        cfg.tap_m1 = cfg_tap_m1;
    end

    assign mis     = rx_bit ^ pred;
    assign chk_upd = rx_en && (ctx_q.state == ST_SYNC);

    bert_rx_patgen u_gen (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .shift_en (rx_en),
        .load_sel (ctx_q.state == ST_LOAD),
        .rx_bit   (rx_bit),
        .pred     (pred)
    );

    bert_rx_errwin #(.WIN(WIN), .THRESH(THRESH)) u_win (
        .clk  (clk),
        .rst  (rst),
        .clr  (ctx_q.state != ST_SYNC),
        .upd  (chk_upd),
        .mis  (mis),
        .trip (trip)
    );

    bert_rx_satcnt #(.W(BIT_W)) u_bits (
        .clk (clk),
        .rst (rst),
        .clr (cnt_clr),
        .inc (chk_upd),
        .q   (bit_cnt)
    );

    bert_rx_satcnt #(.W(ERR_W)) u_errs (
        .clk (clk),
        .rst (rst),
        .clr (cnt_clr),
        .inc (chk_upd && mis),
        .q   (err_cnt)
    );

    always_comb begin
        ctx_nx = ctx_q;
        if (rx_en) begin
            unique case (ctx_q.state)
                ST_LOAD: begin
                    if (ctx_q.idx == LAST) begin
                        ctx_nx.state = ST_VERIFY;
                        ctx_nx.idx   = '0;
                    end else begin
                        ctx_nx.idx = ctx_q.idx + PHASE_W'(1);
                    end
                end
                ST_VERIFY: begin
                    if (mis) begin
                        ctx_nx.state = ST_LOAD;
                        ctx_nx.idx   = '0;
                    end else if (ctx_q.idx == LAST) begin
                        ctx_nx.state = ST_SYNC;
                        ctx_nx.idx   = '0;
                    end else begin
                        ctx_nx.idx = ctx_q.idx + PHASE_W'(1);
                    end
                end
                ST_SYNC: begin
                    if (trip && cfg_auto_resync) begin
                        ctx_nx.state = ST_LOAD;
                        ctx_nx.idx   = '0;
                    end
                end
                default: begin
                    ctx_nx.state = ST_LOAD;
                    ctx_nx.idx   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q.state <= ST_LOAD;
            ctx_q.idx   <= '0;
        end else begin
            ctx_q <= ctx_nx;
        end
    end

    assign in_sync = (ctx_q.state == ST_SYNC);

    AST_SYNC_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(in_sync) |-> $past(ctx_q.state == ST_VERIFY && rx_en && ctx_q.idx == LAST))
        else $error("sync without full verify");  // R4

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        ctx_q.idx <= LAST) else $error("phase index range");  // R4

    AST_VERIFY_FAIL: assert property (@(posedge clk) disable iff (rst)
        (ctx_q.state == ST_VERIFY && rx_en && mis) |=> (ctx_q.state == ST_LOAD && ctx_q.idx == '0))
        else $error("verify mismatch not reloaded");  // R5

    AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && !cnt_clr) |=> ($stable(ctx_q) && $stable(bit_cnt) && $stable(err_cnt)))
        else $error("disabled bit changed state");  // R6

    AST_NO_AUTO_DROP: assert property (@(posedge clk) disable iff (rst)
        (in_sync && !cfg_auto_resync) |=> in_sync) else $error("lock lost with resync off");  // R8

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
        cnt_clr |=> (bit_cnt == '0 && err_cnt == '0)) else $error("clear ignored");  // R11

endmodule

// File: tb/tb_bert_rx_sync.sv
module tb_bert_rx_sync;

    localparam int BW = 10;
    localparam int EW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rx_bit = 1'b0;
    logic          rx_en = 1'b0;
    logic          cfg_repeat = 1'b0;
    logic          cfg_qrss = 1'b0;
    logic [4:0]    cfg_len_m1 = 5'd8;
    logic [4:0]    cfg_tap_m1 = 5'd4;
    logic          cfg_auto_resync = 1'b1;
    logic          cnt_clr = 1'b0;
    logic          in_sync;
    logic [BW-1:0] bit_cnt;
    logic [EW-1:0] err_cnt;

    bert_rx_sync #(.BIT_W(BW), .ERR_W(EW)) dut (
        .clk(clk), .rst(rst), .rx_bit(rx_bit), .rx_en(rx_en),
        .cfg_repeat(cfg_repeat), .cfg_qrss(cfg_qrss),
        .cfg_len_m1(cfg_len_m1), .cfg_tap_m1(cfg_tap_m1),
        .cfg_auto_resync(cfg_auto_resync), .cnt_clr(cnt_clr),
        .in_sync(in_sync), .bit_cnt(bit_cnt), .err_cnt(err_cnt)
    );

    always #2 clk = ~clk;

    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    logic [31:0] tx_g;
    int          tx_n, tx_y;
    bit          tx_rep, tx_q;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Transmit-side pattern model written from R2/R3.
    function automatic logic tx_step();
        logic o;
        if (tx_q)        o = tx_g[16] ^ tx_g[19];
        else if (tx_rep) o = tx_g[tx_n-1];
        else             o = tx_g[tx_n-1] ^ tx_g[tx_y-1];
        if ((tx_q || !tx_rep) && tx_g[30:0] == 31'd0) o = 1'b1;
        if (tx_q && tx_g[13:0] == 14'd0) o = 1'b1;
        tx_g = {tx_g[30:0], o};
        return o;
    endfunction

    task automatic send(bit flip);
        rx_bit = tx_step() ^ flip;
        rx_en  = 1'b1;
        @(negedge clk);
        rx_en  = 1'b0;
    endtask

    task automatic send_clean(int k);
        for (int i = 0; i < k; i++) send(1'b0);
    endtask

    task automatic gap(int k);
        for (int i = 0; i < k; i++) begin
            rx_en  = 1'b0;
            rx_bit = 1'($urandom);
            @(negedge clk);
        end
    endtask

    task automatic clr_pulse();
        cnt_clr = 1'b1;
        rx_en   = 1'b0;
        @(negedge clk);
        cnt_clr = 1'b0;
    endtask

    task automatic setup(bit rep, bit q, int n, int y, logic [31:0] seed, bit auto_rs);
        cfg_repeat      = rep;
        cfg_qrss        = q;
        cfg_len_m1      = 5'(n - 1);
        cfg_tap_m1      = 5'(y - 1);
        cfg_auto_resync = auto_rs;
        tx_rep = rep; tx_q = q; tx_n = n; tx_y = y; tx_g = seed;
        rst = 1'b1;
        rx_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int ns[10];
        int pn[5];
        int py[5];
        ns = '{1, 2, 3, 5, 8, 13, 17, 24, 31, 32};
        pn = '{9, 15, 23, 7, 31};
        py = '{5, 14, 18, 6, 28};

        // R1: reset state
        setup(1'b0, 1'b0, 9, 5, 32'h1, 1'b1);
        chk("R1 in_sync", int'(in_sync), 0);
        chk("R1 bit_cnt", int'(bit_cnt), 0);
        chk("R1 err_cnt", int'(err_cnt), 0);

        // R4: lock exactly after 64 enabled bits
        send_clean(63);
        chk("R4 not yet locked", int'(in_sync), 0);
        chk("R9 no count before lock", int'(bit_cnt), 0);
        send_clean(1);
        chk("R4 locked at 64", int'(in_sync), 1);

        // R9: counting in sync
        send_clean(100);
        chk("R9 bit_cnt", int'(bit_cnt), 100);
        chk("R9 err_cnt", int'(err_cnt), 0);

        // R6: disabled cycles with random data
        gap(20);
        chk("R6 bit_cnt", int'(bit_cnt), 100);
        chk("R6 in_sync", int'(in_sync), 1);
        send(1'b1);
        chk("R9 single error", int'(err_cnt), 1);
        chk("R9 bits after error", int'(bit_cnt), 101);

        // R11: clear beats a simultaneous counted error
        cnt_clr = 1'b1;
        send(1'b1);
        cnt_clr = 1'b0;
        chk("R11 bits cleared", int'(bit_cnt), 0);
        chk("R11 errs cleared", int'(err_cnt), 0);

        // R7: error spacing sweep around the window edge
        setup(1'b0, 1'b0, 15, 14, 32'h5A5, 1'b1);
        send_clean(64);
        chk("R4 prbs15 lock", int'(in_sync), 1);
        for (int s = 10; s <= 14; s++) begin
            clr_pulse();
            for (int k = 0; k < 6; k++) begin
                send(1'b1);
                if (k < 5) send_clean(s - 1);
            end
            chk($sformatf("R7 spacing %0d sync", s), int'(in_sync), (s >= 13) ? 1 : 0);
            chk($sformatf("R7 spacing %0d errs", s), int'(err_cnt), 6);
            if (s <= 12) begin
                send_clean(63);
                chk("R7 relock pending", int'(in_sync), 0);
                send_clean(1);
                chk("R7 relocked", int'(in_sync), 1);
            end else begin
                send_clean(70);
            end
        end

        // R8 and R10: resync off, error counter saturates
        setup(1'b0, 1'b0, 9, 5, 32'h77, 1'b0);
        send_clean(64);
        for (int i = 0; i < 20; i++) send(1'b1);
        chk("R8 held lock", int'(in_sync), 1);
        chk("R10 err saturate", int'(err_cnt), 15);
        chk("R9 bits with errors", int'(bit_cnt), 20);
        clr_pulse();
        send_clean(1100);
        chk("R10 bit saturate", int'(bit_cnt), 1023);
        chk("R10 errs after clear", int'(err_cnt), 0);

        // R5: mismatch during verify restarts acquisition
        setup(1'b0, 1'b0, 9, 5, 32'h1F3, 1'b1);
        send_clean(39);
        send(1'b1);
        send_clean(63);
        chk("R5 still acquiring", int'(in_sync), 0);
        chk("R5 nothing counted", int'(bit_cnt), 0);
        send_clean(1);
        chk("R5 locked after reload", int'(in_sync), 1);

        // R2 and R6: repeating patterns with gaps during acquisition
        foreach (ns[i]) begin
            setup(1'b1, 1'b0, ns[i], 1, 32'h9E3779B9, 1'b1);
            for (int b = 0; b < 63; b++) begin
                send(1'b0);
                if (b % 3 == 0) gap(1);
            end
            chk($sformatf("R6 repeat n=%0d pending", ns[i]), int'(in_sync), 0);
            send_clean(1);
            chk($sformatf("R2 repeat n=%0d lock", ns[i]), int'(in_sync), 1);
            send_clean(50);
            chk($sformatf("R2 repeat n=%0d errs", ns[i]), int'(err_cnt), 0);
            chk($sformatf("R9 repeat n=%0d bits", ns[i]), int'(bit_cnt), 50);
        end

        // R2: several polynomials
        foreach (pn[i]) begin
            setup(1'b0, 1'b0, pn[i], py[i], 32'hACE1, 1'b1);
            send_clean(64);
            chk($sformatf("R2 prbs n=%0d lock", pn[i]), int'(in_sync), 1);
            send_clean(200);
            chk($sformatf("R2 prbs n=%0d errs", pn[i]), int'(err_cnt), 0);
        end

        // R3: all-zero stream never locks in pseudo-random mode
        setup(1'b0, 1'b0, 15, 14, 32'h1, 1'b1);
        for (int i = 0; i < 200; i++) begin
            rx_bit = 1'b0; rx_en = 1'b1;
            @(negedge clk);
        end
        rx_en = 1'b0;
        chk("R3 zero stream no lock", int'(in_sync), 0);

        // R2: all-zero repeating pattern does lock
        setup(1'b1, 1'b0, 8, 1, 32'h0, 1'b1);
        send_clean(64);
        chk("R2 zero repeat lock", int'(in_sync), 1);

        // R3: QRSS lock and clean run
        setup(1'b0, 1'b1, 9, 5, 32'h1, 1'b1);
        send_clean(64);
        chk("R3 qrss lock", int'(in_sync), 1);
        send_clean(3000);
        chk("R3 qrss errs", int'(err_cnt), 0);
        chk("R3 qrss sync held", int'(in_sync), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule